// File: doc/BRIEF.md
# Indirect Channel Configuration Register File

This block holds the configuration of a two-channel disk host adapter behind a narrow pair of host registers. A byte-wide pointer register chooses a channel bank and a register index from 0 to 6, and carries three adapter-wide control bits. A word-wide data port then writes or reads the register the pointer selects. When the pointer's auto-advance bit is set, every data-port access moves the index on by one, so software can stream a whole bank through the data port after a single pointer write.

Each bank holds a command-block base address, a control-block base address, a general configuration byte, a 10-bit read-ahead count with its control bits, and two access-timing bytes. The stored values drive the channel logic continuously. The timing bytes are also decoded here into clock counts. A FIFO-clear request written to the read-ahead control register leaves the block as a one-cycle pulse. Several fields are write-only and read back as zero.

Top module: `cfgreg_ifile`

## Requirements
- R1: After a synchronous reset the pointer reads 0x50 and the data-port read register is 0. Bank 0 holds command base 0x01F0, control base 0x03F6, general byte 0x01, data timing 0xF5 and command timing 0xDE. Bank 1 holds the same values except command base 0x0170 and control base 0x0376. The read-ahead state is 0.
- R2: The pointer layout is: bit 7 auto-advance, bit 6 posted-write wait (output `posted_wait_o`), bit 5 burst disable (output `burst_dis_o`), bit 4 medium device-select timing (output `devsel_med_o`), bit 3 bank, bits 2-0 index. All of these read back as written except bit 5, which always reads 0.
- R3: A data write changes only the bank that pointer bit 3 selects (0 = primary, 1 = secondary), and a read returns that bank's register.
- R4: With pointer bit 7 set, each cycle with a data read or write advances the index by one, and index 6 or 7 wraps to 0. The other pointer bits are unchanged. With bit 7 clear the index holds.
- R5: Indexes 0 (command base) and 4 (control base) store and return all 16 bits.
- R6: Indexes 1, 5 and 6 are byte registers: they store data bits 7-0, ignore bits 15-8 and read back with bits 15-8 at zero. Bit 2 of index 1 (power save) is write-only: it reads as 0 but appears on `gen_cfg_o`.
- R7: Indexes 2 and 3 are write-only and read as 0. `ra_count_o` is {index 3 bits 1-0, index 2 bits 7-0}. Index 3 bit 7 drives `ra_en_o` and bit 4 drives `mode4_o`.
- R8: A write to index 3 with bit 6 set raises `fifo_clr_o` of the selected bank for exactly the one cycle after the write edge. Nothing is stored for it, and the other bank's pulse stays low.
- R9: Index 7 reads as 0, and writes to it change no register of either bank.
- R10: In a timing byte, bits 7-6 give the setup count (code + 1). Bits 5-3 give the hold count: codes 0-5 map to code + 1, code 6 to 8 and code 7 to 12. Bits 2-0 give the active count: codes 0-4 map to code + 2, code 5 to 8, code 6 to 12 and code 7 to 16.
- R11: `dat_rdata` loads the selected register on the edge where `dat_re` is high and holds otherwise. A read and a write of the same register in one cycle return the value from before the write.
- R12: If a pointer write coincides with a data access, the access uses the old pointer and the pointer takes the written value with no auto-advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ptr_we | input | 1 | Pointer write strobe |
| ptr_wdata | input | 8 | Pointer write value |
| ptr_rdata | output | 8 | Pointer read-back value |
| dat_we | input | 1 | Data-port write strobe |
| dat_re | input | 1 | Data-port read strobe |
| dat_wdata | input | 16 | Data-port write value |
| dat_rdata | output | 16 | Data-port read value, registered |
| posted_wait_o | output | 1 | Posted-write wait-state select |
| burst_dis_o | output | 1 | Master burst disable |
| devsel_med_o | output | 1 | Medium device-select timing |
| cmd_base_o | output | 2x16 | Command-block base per bank |
| ctl_base_o | output | 2x16 | Control-block base per bank |
| gen_cfg_o | output | 2x8 | General configuration byte per bank |
| ra_count_o | output | 2x10 | Read-ahead count per bank |
| ra_en_o | output | 2 | Read-ahead enable per bank |
| mode4_o | output | 2 | Mode-4 timing control per bank |
| fifo_clr_o | output | 2 | One-cycle FIFO clear pulse per bank |
| setup_clks_o | output | 2x2x5 | Setup clocks per bank, [0] data port, [1] command port |
| hold_clks_o | output | 2x2x5 | Hold clocks per bank and port |
| active_clks_o | output | 2x2x5 | Active clocks per bank and port |

## Verification
A pointer write and a data-port access can fall in one cycle, and then the auto-advance and the written pointer compete for the index. The bench asserts the pointer strobe with a read strobe on the same edge while auto-advance is set. It then checks that the read returns the register of the old index and that the pointer reads back exactly the written value. A data write and a data read to one register in one cycle are the second case: the captured value must be the one from before the write, and a later read must show the new value.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

    localparam int NCH      = 2;
    localparam int BANK_W   = 1;
    localparam int IDX_W    = 3;
    localparam int NREG     = 7;
    localparam int LAST_IDX = NREG - 1;
    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int RACNT_W  = 10;
    localparam int CLK_W    = 5;
    localparam int NPORT    = 2;

    // bit positions inside the read-ahead control byte
    localparam int RAEN_BIT   = 7;
    localparam int FCLR_BIT   = 6;
    localparam int MODE4_BIT  = 4;

    typedef enum logic [IDX_W-1:0] {
        IX_CMDBASE = 3'd0,
        IX_GENCFG  = 3'd1,
        IX_RALO    = 3'd2,
        IX_RACFG   = 3'd3,
        IX_CTLBASE = 3'd4,
        IX_DTIM    = 3'd5,
        IX_CTIM    = 3'd6,
        IX_NONE    = 3'd7
    } idx_e;

    typedef struct packed {
        logic              autoinc;
        logic              posted_wait;
        logic              burst_dis;
        logic              devsel_med;
        logic [BANK_W-1:0] bank;
        logic [IDX_W-1:0]  idx;
    } ptr_t;

    localparam ptr_t            PTR_RST    = 8'h50;
    localparam logic [BYTE_W-1:0] PTR_RDMASK = 8'hDF;

    typedef struct packed {
        logic dma_en;
        logic drv_rst;
        logic iordy_en;
        logic narrow;
        logic irq_low;
        logic pwr_save;
        logic bus_master;
        logic io_en;
    } gen_t;

    localparam logic [BYTE_W-1:0] GEN_RDMASK = 8'hFB;

    typedef struct packed {
        logic [1:0] setup;
        logic [2:0] hold;
        logic [2:0] active;
    } tim_t;

    typedef struct packed {
        logic [CLK_W-1:0] setup;
        logic [CLK_W-1:0] hold;
        logic [CLK_W-1:0] active;
    } tclk_t;

    typedef struct packed {
        logic [WORD_W-1:0]  cmd_base;
        logic [WORD_W-1:0]  ctl_base;
        gen_t               gen;
        logic [RACNT_W-1:0] ra_count;
        logic               ra_en;
        logic               mode4;
        tim_t               dtim;
        tim_t               ctim;
    } bank_t;

    function automatic bank_t bank_default(input logic ch);
        bank_t b;
        b.cmd_base = ch ? 16'h0170 : 16'h01F0;
        b.ctl_base = ch ? 16'h0376 : 16'h03F6;
        b.gen      = 8'h01;
        b.ra_count = '0;
        b.ra_en    = 1'b0;
        b.mode4    = 1'b0;
        b.dtim     = 8'hF5;
        b.ctim     = 8'hDE;
        return b;
    endfunction

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
        return (i >= IDX_W'(LAST_IDX)) ? '0 : i + IDX_W'(1);
    endfunction

    function automatic tclk_t decode_timing(input tim_t t);
        tclk_t c;
        case (t.setup)
            2'd0:    c.setup = CLK_W'(1);
            2'd1:    c.setup = CLK_W'(2);
            2'd2:    c.setup = CLK_W'(3);
            default: c.setup = CLK_W'(4);
        endcase
        case (t.hold)
            3'd0:    c.hold = CLK_W'(1);
            3'd1:    c.hold = CLK_W'(2);
            3'd2:    c.hold = CLK_W'(3);
            3'd3:    c.hold = CLK_W'(4);
            3'd4:    c.hold = CLK_W'(5);
            3'd5:    c.hold = CLK_W'(6);
            3'd6:    c.hold = CLK_W'(8);
            default: c.hold = CLK_W'(12);
        endcase
        case (t.active)
            3'd0:    c.active = CLK_W'(2);
            3'd1:    c.active = CLK_W'(3);
            3'd2:    c.active = CLK_W'(4);
            3'd3:    c.active = CLK_W'(5);
            3'd4:    c.active = CLK_W'(6);
            3'd5:    c.active = CLK_W'(8);
            3'd6:    c.active = CLK_W'(12);
            default: c.active = CLK_W'(16);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cfgreg_ptr.sv
module cfgreg_ptr
    import cfgreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_we,
    input  logic [BYTE_W-1:0] ptr_wdata,
    input  logic              access,
    output ptr_t              ptr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= PTR_RST;
        end else if (ptr_we) begin
            // an explicit pointer write wins over auto-advance
            ptr <= ptr_t'(ptr_wdata);
        end else if (access && ptr.autoinc) begin
            ptr.idx <= next_idx(ptr.idx);
        end
    end

endmodule

// File: rtl/cfgreg_bank.sv
module cfgreg_bank
    import cfgreg_pkg::*;
#(
    parameter logic CH_ID = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output bank_t             regs,
    output logic [WORD_W-1:0] rd_word,
    output logic              fifo_clr
);

    localparam int PAD_W = WORD_W - BYTE_W;
    localparam int RAHI_W = RACNT_W - BYTE_W;

    idx_e sel_idx;
    assign sel_idx = idx_e'(idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs     <= bank_default(CH_ID);
            fifo_clr <= 1'b0;
        end else begin
            fifo_clr <= wr && (sel_idx == IX_RACFG) && wdata[FCLR_BIT];
            if (wr) begin
                case (sel_idx)
                    IX_CMDBASE: regs.cmd_base <= wdata;
                    IX_GENCFG:  regs.gen      <= gen_t'(wdata[BYTE_W-1:0]);
                    IX_RALO:    regs.ra_count[BYTE_W-1:0] <= wdata[BYTE_W-1:0];
                    IX_RACFG: begin
                        regs.ra_en <= wdata[RAEN_BIT];
                        regs.mode4 <= wdata[MODE4_BIT];
                        regs.ra_count[RACNT_W-1:BYTE_W] <= wdata[RAHI_W-1:0];
                    end
                    IX_CTLBASE: regs.ctl_base <= wdata;
                    IX_DTIM:    regs.dtim     <= tim_t'(wdata[BYTE_W-1:0]);
                    IX_CTIM:    regs.ctim     <= tim_t'(wdata[BYTE_W-1:0]);
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (sel_idx)
            IX_CMDBASE: rd_word = regs.cmd_base;
            IX_GENCFG:  rd_word = {{PAD_W{1'b0}}, (BYTE_W'(regs.gen) & GEN_RDMASK)};
            IX_CTLBASE: rd_word = regs.ctl_base;
            IX_DTIM:    rd_word = {{PAD_W{1'b0}}, BYTE_W'(regs.dtim)};
            IX_CTIM:    rd_word = {{PAD_W{1'b0}}, BYTE_W'(regs.ctim)};
            default:    rd_word = '0;
        endcase
    end

endmodule

// File: rtl/cfgreg_timing_dec.sv
module cfgreg_timing_dec
    import cfgreg_pkg::*;
(
    input  tim_t  code,
    output tclk_t clks
);

    always_comb begin
        clks = decode_timing(code);
    end

endmodule

// File: rtl/cfgreg_ifile.sv
module cfgreg_ifile
    import cfgreg_pkg::*;
(
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    ptr_we,
    input  logic [BYTE_W-1:0]                       ptr_wdata,
    output logic [BYTE_W-1:0]                       ptr_rdata,
    input  logic                                    dat_we,
    input  logic                                    dat_re,
    input  logic [WORD_W-1:0]                       dat_wdata,
    output logic [WORD_W-1:0]                       dat_rdata,
    output logic                                    posted_wait_o,
    output logic                                    burst_dis_o,
    output logic                                    devsel_med_o,
    output logic [NCH-1:0][WORD_W-1:0]              cmd_base_o,
    output logic [NCH-1:0][WORD_W-1:0]              ctl_base_o,
    output logic [NCH-1:0][BYTE_W-1:0]              gen_cfg_o,
    output logic [NCH-1:0][RACNT_W-1:0]             ra_count_o,
    output logic [NCH-1:0]                          ra_en_o,
    output logic [NCH-1:0]                          mode4_o,
    output logic [NCH-1:0]                          fifo_clr_o,
    output logic [NCH-1:0][NPORT-1:0][CLK_W-1:0]    setup_clks_o,
    output logic [NCH-1:0][NPORT-1:0][CLK_W-1:0]    hold_clks_o,
    output logic [NCH-1:0][NPORT-1:0][CLK_W-1:0]    active_clks_o
);

    ptr_t              ptr;
    bank_t             bank_q  [NCH];
    logic [WORD_W-1:0] rd_word [NCH];

    cfgreg_ptr u_ptr (
        .clk       (clk),
        .rst       (rst),
        .ptr_we    (ptr_we),
        .ptr_wdata (ptr_wdata),
        .access    (dat_we || dat_re),
        .ptr       (ptr)
    );

    assign ptr_rdata     = BYTE_W'(ptr) & PTR_RDMASK;
    assign posted_wait_o = ptr.posted_wait;
    assign burst_dis_o   = ptr.burst_dis;
    assign devsel_med_o  = ptr.devsel_med;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel;
        assign sel = (ptr.bank == BANK_W'(c));

        cfgreg_bank #(.CH_ID(1'(c))) u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr       (dat_we && sel),
            .idx      (ptr.idx),
            .wdata    (dat_wdata),
            .regs     (bank_q[c]),
            .rd_word  (rd_word[c]),
            .fifo_clr (fifo_clr_o[c])
        );

        assign cmd_base_o[c] = bank_q[c].cmd_base;
        assign ctl_base_o[c] = bank_q[c].ctl_base;
        assign gen_cfg_o[c]  = BYTE_W'(bank_q[c].gen);
        assign ra_count_o[c] = bank_q[c].ra_count;
        assign ra_en_o[c]    = bank_q[c].ra_en;
        assign mode4_o[c]    = bank_q[c].mode4;

        for (genvar p = 0; p < NPORT; p++) begin : g_port
            tim_t  code;
            tclk_t clks;
            if (p == 0) begin : g_data
                assign code = bank_q[c].dtim;
            end else begin : g_cmd
                assign code = bank_q[c].ctim;
            end

            cfgreg_timing_dec u_dec (
                .code (code),
                .clks (clks)
            );

            assign setup_clks_o[c][p]  = clks.setup;
            assign hold_clks_o[c][p]   = clks.hold;
            assign active_clks_o[c][p] = clks.active;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_rdata <= '0;
        end else if (dat_re) begin
            dat_rdata <= rd_word[ptr.bank];
        end
    end

endmodule

// File: rtl/cfgreg_ifile_chk.sv
module cfgreg_ifile_chk
    import cfgreg_pkg::*;
(
    input logic                                 clk,
    input logic                                 rst,
    input logic                                 ptr_we,
    input logic [BYTE_W-1:0]                    ptr_wdata,
    input logic [BYTE_W-1:0]                    ptr_rdata,
    input logic                                 dat_we,
    input logic                                 dat_re,
    input logic [WORD_W-1:0]                    dat_rdata,
    input logic [NCH-1:0][WORD_W-1:0]           cmd_base_o,
    input logic [NCH-1:0][WORD_W-1:0]           ctl_base_o,
    input logic [NCH-1:0][BYTE_W-1:0]           gen_cfg_o,
    input logic [NCH-1:0]                       fifo_clr_o,
    input logic [NCH-1:0][NPORT-1:0][CLK_W-1:0] setup_clks_o,
    input logic [NCH-1:0][NPORT-1:0][CLK_W-1:0] hold_clks_o,
    input logic [NCH-1:0][NPORT-1:0][CLK_W-1:0] active_clks_o
);

    AST_PTR_WRITE: assert property (@(posedge clk) disable iff (rst)
        ptr_we |=> ptr_rdata == ($past(ptr_wdata) & PTR_RDMASK)); // R12

    AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (!ptr_we && (dat_we || dat_re) && ptr_rdata[7])
        |=> ptr_rdata[IDX_W-1:0] == next_idx($past(ptr_rdata[IDX_W-1:0]))); // R4

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ptr_we && !dat_we && !dat_re) |=> $stable(ptr_rdata)); // R4

    AST_PTR_BIT5_ZERO: assert property (@(posedge clk) disable iff (rst)
        ptr_rdata[5] == 1'b0); // R2

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dat_re |=> $stable(dat_rdata)); // R11

    AST_IDX7_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (dat_we && !ptr_we && ptr_rdata[IDX_W-1:0] == 3'd7)
        |=> ($stable(cmd_base_o) && $stable(ctl_base_o) && $stable(gen_cfg_o))); // R9

    AST_FIFO_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fifo_clr_o)); // R8

    for (genvar c = 0; c < NCH; c++) begin : g_fc
        AST_FIFO_SINGLE: assert property (@(posedge clk) disable iff (rst)
            fifo_clr_o[c] |=> !fifo_clr_o[c]); // R8
        AST_FIFO_CAUSE: assert property (@(posedge clk) disable iff (rst)
            $rose(fifo_clr_o[c]) |-> $past(dat_we)); // R8
        for (genvar p = 0; p < NPORT; p++) begin : g_fp
            AST_TIMING_RANGE: assert property (@(posedge clk) disable iff (rst)
                (setup_clks_o[c][p] >= 5'd1 && setup_clks_o[c][p] <= 5'd4 &&
                 hold_clks_o[c][p] >= 5'd1 && hold_clks_o[c][p] <= 5'd12 &&
                 active_clks_o[c][p] >= 5'd2 && active_clks_o[c][p] <= 5'd16)); // R10
        end
    end

endmodule

bind cfgreg_ifile cfgreg_ifile_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ptr_we        (ptr_we),
    .ptr_wdata     (ptr_wdata),
    .ptr_rdata     (ptr_rdata),
    .dat_we        (dat_we),
    .dat_re        (dat_re),
    .dat_rdata     (dat_rdata),
    .cmd_base_o    (cmd_base_o),
    .ctl_base_o    (ctl_base_o),
    .gen_cfg_o     (gen_cfg_o),
    .fifo_clr_o    (fifo_clr_o),
    .setup_clks_o  (setup_clks_o),
    .hold_clks_o   (hold_clks_o),
    .active_clks_o (active_clks_o)
);

// File: tb/cfgreg_ifile_tb.sv
`timescale 1ns/1ps
module cfgreg_ifile_tb;
    import cfgreg_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ptr_we = 1'b0;
    logic [7:0] ptr_wdata = '0;
    logic [7:0] ptr_rdata;
    logic dat_we = 1'b0;
    logic dat_re = 1'b0;
    logic [15:0] dat_wdata = '0;
    logic [15:0] dat_rdata;
    logic posted_wait_o, burst_dis_o, devsel_med_o;
    logic [1:0][15:0] cmd_base_o, ctl_base_o;
    logic [1:0][7:0]  gen_cfg_o;
    logic [1:0][9:0]  ra_count_o;
    logic [1:0]       ra_en_o, mode4_o, fifo_clr_o;
    logic [1:0][1:0][4:0] setup_clks_o, hold_clks_o, active_clks_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cfgreg_ifile u_dut (
        .clk(clk), .rst(rst),
        .ptr_we(ptr_we), .ptr_wdata(ptr_wdata), .ptr_rdata(ptr_rdata),
        .dat_we(dat_we), .dat_re(dat_re), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .posted_wait_o(posted_wait_o), .burst_dis_o(burst_dis_o), .devsel_med_o(devsel_med_o),
        .cmd_base_o(cmd_base_o), .ctl_base_o(ctl_base_o), .gen_cfg_o(gen_cfg_o),
        .ra_count_o(ra_count_o), .ra_en_o(ra_en_o), .mode4_o(mode4_o), .fifo_clr_o(fifo_clr_o),
        .setup_clks_o(setup_clks_o), .hold_clks_o(hold_clks_o), .active_clks_o(active_clks_o)
    );

    // {req[3:0], op[1:0] (0 pointer, 1 write, 2 read), value[15:0], expected[15:0]}
    localparam int NV = 27;
    localparam logic [37:0] TBL [NV] = '{
        {4'd2,  2'd0, 16'h0080, 16'h0000},
        {4'd1,  2'd2, 16'h0000, 16'h01F0}, // R1 bank0 command base
        {4'd1,  2'd2, 16'h0000, 16'h0001}, // R1 general byte
        {4'd7,  2'd2, 16'h0000, 16'h0000}, // R7 index 2 reads zero
        {4'd7,  2'd2, 16'h0000, 16'h0000}, // R7 index 3 reads zero
        {4'd1,  2'd2, 16'h0000, 16'h03F6}, // R1 control base
        {4'd1,  2'd2, 16'h0000, 16'h00F5}, // R1 data timing
        {4'd1,  2'd2, 16'h0000, 16'h00DE}, // R1 command timing, wraps
        {4'd4,  2'd2, 16'h0000, 16'h01F0}, // R4 index 6 wrapped to 0
        {4'd3,  2'd0, 16'h0088, 16'h0000},
        {4'd3,  2'd2, 16'h0000, 16'h0170}, // R3 bank1 command base
        {4'd3,  2'd0, 16'h0088, 16'h0000},
        {4'd5,  2'd1, 16'hBEEF, 16'h0000},
        {4'd6,  2'd1, 16'hFF27, 16'h0000},
        {4'd3,  2'd0, 16'h0008, 16'h0000},
        {4'd5,  2'd2, 16'h0000, 16'hBEEF}, // R5 full word stored
        {4'd4,  2'd2, 16'h0000, 16'hBEEF}, // R4 no advance when bit7 clear
        {4'd3,  2'd0, 16'h0001, 16'h0000},
        {4'd3,  2'd2, 16'h0000, 16'h0001}, // R3 bank0 untouched
        {4'd6,  2'd0, 16'h0009, 16'h0000},
        {4'd6,  2'd2, 16'h0000, 16'h0023}, // R6 upper byte dropped, bit2 hidden
        {4'd5,  2'd0, 16'h000C, 16'h0000},
        {4'd5,  2'd1, 16'h1234, 16'h0000},
        {4'd5,  2'd2, 16'h0000, 16'h1234}, // R5 control base word
        {4'd6,  2'd0, 16'h0005, 16'h0000},
        {4'd6,  2'd1, 16'hAB9C, 16'h0000},
        {4'd6,  2'd2, 16'h0000, 16'h009C}  // R6 timing byte
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic ptr_write(input logic [7:0] v);
        @(negedge clk); ptr_we = 1'b1; ptr_wdata = v;
        @(negedge clk); ptr_we = 1'b0;
    endtask

    task automatic data_write(input logic [15:0] v);
        @(negedge clk); dat_we = 1'b1; dat_wdata = v;
        @(negedge clk); dat_we = 1'b0;
    endtask

    task automatic data_read();
        @(negedge clk); dat_re = 1'b1;
        @(negedge clk); dat_re = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] snap_cmd, snap_ctl;
        logic [7:0]  snap_gen;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 pointer reset", ptr_rdata, 8'h50);
        chk("R1 read data reset", dat_rdata, 16'h0);
        chk("R1 cmd base bank1", cmd_base_o[1], 16'h0170);
        chk("R1 ctl base bank1", ctl_base_o[1], 16'h0376);
        chk("R1 read-ahead reset", {ra_en_o, mode4_o, ra_count_o[0]}, 0);
        // R10 decode of defaults: 0xF5 -> 4/8/8, 0xDE -> 4/4/12
        chk("R10 data port default", {setup_clks_o[0][0], hold_clks_o[0][0], active_clks_o[0][0]},
            {5'd4, 5'd8, 5'd8});
        chk("R10 cmd port default", {setup_clks_o[1][1], hold_clks_o[1][1], active_clks_o[1][1]},
            {5'd4, 5'd4, 5'd12});

        // R2 pointer read-back and global bits
        ptr_write(8'hFF);
        chk("R2 pointer readback", ptr_rdata, 8'hDF);
        chk("R2 global bits", {posted_wait_o, burst_dis_o, devsel_med_o}, 3'b111);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [37:0] e;
            e = TBL[i];
            case (e[33:32])
                2'd0: ptr_write(e[23:16]);
                2'd1: data_write(e[31:16]);
                default: begin
                    data_read();
                    chk($sformatf("R%0d table entry %0d", e[37:34], i), dat_rdata, e[15:0]);
                end
            endcase
        end
        chk("R5 bank1 cmd base out", cmd_base_o[1], 16'hBEEF);
        chk("R6 gen output keeps power save", gen_cfg_o[1], 8'h27);
        chk("R10 decode 0x9C", {setup_clks_o[0][0], hold_clks_o[0][0], active_clks_o[0][0]},
            {5'd3, 5'd4, 5'd6});

        // R10 top codes: bank1 data timing 0x3F -> 1/12/16
        ptr_write(8'h0D);
        data_write(16'h003F);
        chk("R10 decode 0x3F", {setup_clks_o[1][0], hold_clks_o[1][0], active_clks_o[1][0]},
            {5'd1, 5'd12, 5'd16});

        // R7 read-ahead count and control
        ptr_write(8'h02);
        data_write(16'h0155);
        ptr_write(8'h03);
        data_write(16'h00D3);
        // R8 pulse is visible in the cycle after the write edge
        chk("R8 fifo clear pulse", fifo_clr_o, 2'b01);
        chk("R7 read-ahead count", ra_count_o[0], 10'h355);
        chk("R7 enable and mode4", {ra_en_o[0], mode4_o[0]}, 2'b11);
        @(negedge clk);
        chk("R8 fifo clear one cycle", fifo_clr_o, 2'b00);
        data_read();
        chk("R7 index 3 reads zero", dat_rdata, 16'h0);
        data_write(16'h0080);
        chk("R8 no pulse without bit6", fifo_clr_o, 2'b00);

        // R9 index 7
        ptr_write(8'h07);
        snap_cmd = cmd_base_o[0];
        snap_ctl = ctl_base_o[0];
        snap_gen = gen_cfg_o[0];
        data_write(16'hFFFF);
        chk("R9 index 7 write ignored", {cmd_base_o[0], ctl_base_o[0], gen_cfg_o[0]},
            {snap_cmd, snap_ctl, snap_gen});
        data_read();
        chk("R9 index 7 reads zero", dat_rdata, 16'h0);

        // R4 wrap from index 7
        ptr_write(8'h87);
        data_read();
        chk("R4 wrap from index 7", ptr_rdata, 8'h80);

        // R12 pointer write coinciding with a read
        ptr_write(8'h81);
        @(negedge clk); dat_re = 1'b1; ptr_we = 1'b1; ptr_wdata = 8'h05;
        @(negedge clk); dat_re = 1'b0; ptr_we = 1'b0;
        chk("R12 access uses old pointer", dat_rdata, 16'h0001);
        chk("R12 pointer takes written value", ptr_rdata, 8'h05);

        // R11 same-cycle write and read
        ptr_write(8'h06);
        @(negedge clk); dat_re = 1'b1; dat_we = 1'b1; dat_wdata = 16'h0011;
        @(negedge clk); dat_re = 1'b0; dat_we = 1'b0;
        chk("R11 read returns old value", dat_rdata, 16'h00DE);
        @(negedge clk);
        chk("R11 read data holds", dat_rdata, 16'h00DE);
        data_read();
        chk("R11 new value after write", dat_rdata, 16'h0011);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule